// File: doc/BRIEF.md
# SMBus Byte-Protocol Register Target

This block is a target-only SMBus interface that lets a host reach a bank of 8-bit registers kept outside the block. It watches a synchronised copy of SCL and SDA, recognises START and STOP conditions, decodes its own 7-bit device address, and pulls SDA low through an output-enable to acknowledge or to send read data. It never begins a bus transaction and never stretches the clock.

Four transactions are understood. Write Byte and Read Byte carry a command byte. Send Byte and Receive Byte carry none. A single register pointer connects them. The first byte after a write address always loads the pointer, so a Send Byte and the command byte of a Write Byte or Read Byte take the same path. The second byte of a write transaction is stored at the pointer. A read address returns the register the pointer selects. The pointer persists across transactions, so a Receive Byte reads wherever the last command or Send Byte left it.

The register side is a plain port: the pointer is driven out as an address, the received byte as write data with a one-cycle write strobe, and a one-cycle read strobe marks the cycle in which the read data input is captured for transmission.

Top module: `smb_byte_slave`

## Requirements
- R1: After reset, sdaOe, regWe and regRe are 0 and regAddr is 0.
- R2: An address byte, sent MSB first with the 7-bit address in bits 7:1 and the read flag (1 = read) in bit 0, that matches DEV_ADDR (default 0x2A) is acknowledged by pulling SDA low during the ninth clock.
- R3: A non-matching address is not acknowledged. The block then leaves SDA released and touches no register until the next START.
- R4: A write transaction that carries one byte (Send Byte) loads that byte into the pointer, which appears on regAddr, and writes no register.
- R5: In a write transaction, the byte after the first (Write Byte data) is acknowledged and written once to the register that the first byte selected, with a single-cycle regWe.
- R6: Any byte after the second in a write transaction is not acknowledged and causes no write.
- R7: A read address with no command byte (Receive Byte) returns, MSB first, the register the current pointer selects, with one regRe pulse.
- R8: A command byte followed by a repeated START and a read address (Read Byte) returns the register that the command byte selected.
- R9: The pointer keeps its value across STOP and across transactions.
- R10: Only one data byte is returned per read address. If the host acknowledges it, the block leaves SDA released, so further reads see 0xFF.
- R11: The block changes sdaOe only while SCL is low, so it never produces a START or STOP.
- R12: Transactions work for any SCL high and low time of at least 6 clk cycles, covering the 10 kHz to 400 kHz range with a fast enough clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | 8 | Register pointer |
| regWdata | output | 8 | Byte to write |
| regWe | output | 1 | One-cycle write strobe |
| regRe | output | 1 | One-cycle strobe; regRdata captured this cycle |
| regRdata | input | 8 | Data of the register at regAddr |

## Verification
On every cycle, the assertions check the timing rules: SDA is only moved while SCL is low, SDA stays released in the idle state, each write strobe is a single pulse that leads into an acknowledge, and each read strobe leads straight into transmission. Only the bench's scenarios can show the transaction-level meaning. That covers the pointer being loaded by Send Byte and surviving STOP, Write Byte storing at the commanded register, a third write byte being NACKed, repeated-START reads returning the right byte, a foreign address being ignored, and correct operation at a slow and a fast SCL rate.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TXACK
  } smbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic loadPtr;
    logic writeReg;
  } dpCtl_t;
endpackage

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR   = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              sclLvl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic [BYTE_W-1:0] shiftByte,
  output logic [BYTE_W-1:0] ptr
);
  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclP, sdaP;
  logic [BYTE_W-1:0] shiftQ, ptrQ;

  // input synchronisers, reset to the idle (released) bus level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclP     <= sclS;
      sdaP     <= sdaS;
    end
  end

  assign sclS    = sclChain[SYNC_STAGES-1];
  assign sdaS    = sdaChain[SYNC_STAGES-1];
  assign sclLvl  = sclS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

  // one shift register serves receive and transmit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      ptrQ   <= '0;
    end else begin
      if (ctl.shiftIn)      shiftQ <= {shiftQ[BYTE_W-2:0], sdaS};
      else if (ctl.loadTx)  shiftQ <= regRdata;
      else if (ctl.shiftTx) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b1};
      if (ctl.loadPtr)      ptrQ   <= shiftQ;
    end
  end

  assign addrMatch = (shiftQ[BYTE_W-1:1] == DEV_ADDR);
  assign rwBit     = shiftQ[0];
  assign txBit     = shiftQ[BYTE_W-1];
  assign shiftByte = shiftQ;
  assign ptr       = ptrQ;
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startEv,
  input  logic      stopEv,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txBit,
  output dpCtl_t    ctl,
  output logic      sdaOe,
  output smbState_t state
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

  smbState_t stateQ, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic [1:0] byteCnt, byteCntN;
  logic ackOn, ackOnN, isRead, isReadN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      ackOn   <= 1'b0;
      isRead  <= 1'b0;
    end else begin
      stateQ  <= stateN;
      bitCnt  <= bitCntN;
      byteCnt <= byteCntN;
      ackOn   <= ackOnN;
      isRead  <= isReadN;
    end
  end

  always_comb begin
    stateN   = stateQ;
    bitCntN  = bitCnt;
    byteCntN = byteCnt;
    ackOnN   = ackOn;
    isReadN  = isRead;
    ctl      = '0;
    if (stopEv) begin
      stateN = ST_IDLE;
    end else if (startEv) begin
      stateN   = ST_ADDR;
      bitCntN  = '0;
      byteCntN = '0;
    end else begin
      case (stateQ)
        ST_ADDR: begin
          if (sclRise && bitCnt != BIT_LAST) begin
            ctl.shiftIn = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BIT_LAST) begin
            if (addrMatch) begin
              stateN  = ST_ACK;
              ackOnN  = 1'b1;
              isReadN = rwBit;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (isRead) begin
              stateN     = ST_TX;
              ctl.loadTx = 1'b1;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (sclRise && bitCnt != BIT_LAST) begin
            ctl.shiftIn = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BIT_LAST) begin
            stateN = ST_ACK;
            if (byteCnt == 2'd0) begin
              ctl.loadPtr = 1'b1;
              ackOnN      = 1'b1;
            end else if (byteCnt == 2'd1) begin
              ctl.writeReg = 1'b1;
              ackOnN       = 1'b1;
            end else begin
              ackOnN = 1'b0;
            end
            if (byteCnt != 2'd2) byteCntN = byteCnt + 1'b1;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == TX_LAST) begin
              stateN = ST_TXACK;
            end else begin
              ctl.shiftTx = 1'b1;
              bitCntN     = bitCnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclFall) stateN = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ((stateQ == ST_ACK) && ackOn) || ((stateQ == ST_TX) && !txBit);
  assign state = stateQ;
endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave
  import smb_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR   = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [BYTE_W-1:0] regRdata
);
  dpCtl_t    ctl;
  smbState_t ctrlState;
  logic sclLvl, sclRise, sclFall, startEv, stopEv;
  logic addrMatch, rwBit, txBit;

  smb_datapath #(.SYNC_STAGES(SYNC_STAGES), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .regRdata(regRdata), .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .addrMatch(addrMatch), .rwBit(rwBit),
    .txBit(txBit), .shiftByte(regWdata), .ptr(regAddr)
  );

  smb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .addrMatch(addrMatch), .rwBit(rwBit),
    .txBit(txBit), .ctl(ctl), .sdaOe(sdaOe), .state(ctrlState)
  );

  assign regWe = ctl.writeReg;
  assign regRe = ctl.loadTx;
endmodule

// File: rtl/smb_byte_slave_chk.sv
module smb_byte_slave_chk
  import smb_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclLvl,
  input logic      sdaOe,
  input logic      regWe,
  input logic      regRe,
  input smbState_t state
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R3

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl); // R11

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R5

  AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (state == ST_ACK)); // R5

  AST_RE_STARTS_TX: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> (state == ST_TX)); // R7

  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe); // R10
endmodule

bind smb_byte_slave smb_byte_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaOe(sdaOe),
  .regWe(regWe), .regRe(regRe), .state(ctrlState)
);

// File: tb/tb_smb_byte_slave.sv
module tb_smb_byte_slave;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic sdaOe, regWe, regRe;
  logic [7:0] regAddr, regWdata, regRdata;
  logic sdaLine;
  logic [7:0] bank [256];
  int weCnt = 0, reCnt = 0, oeViol = 0;
  int tests = 0, fails = 0;
  int hp = 8;
  bit done = 0;
  logic prevOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine  = !(mLow | sdaOe);
  assign regRdata = bank[regAddr];

  smb_byte_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  // external register bank and bus monitor
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) bank[i] = 8'(i) ^ 8'h5A;
    end else begin
      if (regWe) begin bank[regAddr] = regWdata; weCnt++; end
      if (regRe) reCnt++;
      if (sdaOe != prevOe && scl) oeViol++;
    end
    prevOe = sdaOe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mStart();
    mLow = 0; scl = 1; tick(hp); mLow = 1; tick(hp); scl = 0; tick(1);
  endtask

  task automatic mRestart();
    mLow = 0; tick(hp); scl = 1; tick(hp); mLow = 1; tick(hp); scl = 0; tick(1);
  endtask

  task automatic mStop();
    mLow = 1; tick(hp); scl = 1; tick(hp); mLow = 0; tick(hp);
  endtask

  task automatic mSend(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mLow = !b[i]; tick(hp); scl = 1; tick(hp); scl = 0; tick(1);
    end
    mLow = 0; tick(hp); scl = 1; tick(hp/2);
    acked = !sdaLine;
    tick(hp - hp/2); scl = 0; tick(1);
  endtask

  task automatic mRead(input bit ackIt, output logic [7:0] d);
    mLow = 0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(hp); scl = 1; tick(hp/2);
      d = {d[6:0], sdaLine};
      tick(hp - hp/2); scl = 0; tick(1);
    end
    mLow = ackIt; tick(hp); scl = 1; tick(hp); scl = 0; tick(1); mLow = 0;
  endtask

  task automatic tReset();
    check(sdaOe == 0, "R1 sdaOe", sdaOe, 0);
    check(regWe == 0 && regRe == 0, "R1 strobes", {regWe, regRe}, 0);
    check(regAddr == 0, "R1 regAddr", regAddr, 0);
  endtask

  task automatic tSendByte(input logic [7:0] p);
    bit a1, a2; int we0 = weCnt;
    mStart(); mSend({DEV, 1'b0}, a1); mSend(p, a2); mStop();
    check(a1, "R2 address ACK", a1, 1);
    check(a2, "R4 send byte ACK", a2, 1);
    check(regAddr == p, "R4 pointer", regAddr, p);
    check(weCnt == we0, "R4 no write", weCnt, we0);
  endtask

  task automatic tReceiveByte(input logic [7:0] exp);
    bit a; logic [7:0] d; int re0 = reCnt;
    mStart(); mSend({DEV, 1'b1}, a); mRead(1'b1, d); mStop();
    check(a, "R7 read address ACK", a, 1);
    check(d == exp, "R7 R9 receive byte data", d, exp);
    check(reCnt == re0 + 1, "R7 single regRe", reCnt, re0 + 1);
  endtask

  task automatic tWriteByte(input logic [7:0] c, input logic [7:0] v, input string req);
    bit a0, a1, a2; int we0 = weCnt;
    mStart(); mSend({DEV, 1'b0}, a0); mSend(c, a1); mSend(v, a2); mStop();
    check(a0 && a1 && a2, {req, " write byte ACKs"}, {a0, a1, a2}, 3'b111);
    check(bank[c] == v, {req, " stored data"}, bank[c], v);
    check(weCnt == we0 + 1, {req, " one write"}, weCnt, we0 + 1);
  endtask

  task automatic tExtraByte();
    bit a0, a1, a2, a3; int we0 = weCnt;
    logic [7:0] keep = bank[8'h77];
    mStart(); mSend({DEV, 1'b0}, a0); mSend(8'h11, a1); mSend(8'h3C, a2);
    mSend(8'h77, a3); mStop();
    check(!a3, "R6 extra byte NACK", a3, 0);
    check(bank[8'h11] == 8'h3C, "R6 data kept", bank[8'h11], 8'h3C);
    check(weCnt == we0 + 1 && bank[8'h77] == keep, "R6 no extra write", weCnt, we0 + 1);
  endtask

  task automatic tWrongAddr();
    bit a0, a1; int we0 = weCnt; logic [7:0] p0 = regAddr;
    mStart(); mSend({7'h2B, 1'b0}, a0); mSend(8'h99, a1); mStop();
    check(!a0, "R3 foreign address NACK", a0, 0);
    check(!a1, "R3 following byte ignored", a1, 0);
    check(regAddr == p0 && weCnt == we0, "R3 no register access", regAddr, p0);
  endtask

  task automatic tReadByte(input logic [7:0] c, input logic [7:0] exp, input string req);
    bit a0, a1, a2; logic [7:0] d;
    mStart(); mSend({DEV, 1'b0}, a0); mSend(c, a1);
    mRestart(); mSend({DEV, 1'b1}, a2); mRead(1'b1, d); mStop();
    check(a0 && a1 && a2, {req, " read byte ACKs"}, {a0, a1, a2}, 3'b111);
    check(d == exp, {req, " read byte data"}, d, exp);
  endtask

  task automatic tReadPastEnd();
    bit a; logic [7:0] d0, d1;
    mStart(); mSend({DEV, 1'b1}, a); mRead(1'b0, d0); mRead(1'b1, d1); mStop();
    check(d0 == 8'hA5, "R10 first byte", d0, 8'hA5);
    check(d1 == 8'hFF, "R10 released after ACK", d1, 8'hFF);
    check(sdaOe == 0, "R10 line released", sdaOe, 0);
  endtask

  initial begin
    tick(5);
    rstN = 1;
    tick(3);
    tReset();
    tSendByte(8'h35);
    tReceiveByte(8'h35 ^ 8'h5A);
    tWriteByte(8'h10, 8'hA5, "R5");
    tExtraByte();
    tWrongAddr();
    tReadByte(8'h10, 8'hA5, "R8");
    tReadPastEnd();
    tSendByte(8'h11);
    tReceiveByte(8'h3C);
    hp = 40;
    tWriteByte(8'h20, 8'hC3, "R12 slow");
    tReadByte(8'h20, 8'hC3, "R12 slow");
    hp = 6;
    tWriteByte(8'h21, 8'h18, "R12 fast");
    tReadByte(8'h21, 8'h18, "R12 fast");
    check(oeViol == 0, "R11 sdaOe moved with SCL high", oeViol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule